// File: doc/BRIEF.md
# Frame DMA Channel Arbiter

This block decides which of eight frame DMA channels may move data at any moment. Six channels carry frames from memory towards the switch. Two channels carry frames from the switch towards memory. Each channel is attached to one of two CPU ports. The four lowest-index outbound channels and the two upper ones map to a port through a run-time selection bit per channel. The two inbound channels are fixed: one per port. Every channel raises a request, has an enable bit, and marks the last beat of each frame it moves. The arbiter returns a registered one-hot grant, the port that the granted channel serves, and a busy flag.

A grant is held for a whole frame. A new decision is taken only when no channel holds the grant, or in the cycle where the holder signals its last beat. In that cycle the next owner is chosen, so no idle cycle appears between frames. Each port first picks its own candidate: its inbound channel if that channel is requesting, and otherwise the highest-numbered outbound channel mapped to it. When both ports have a candidate, the ports take turns. All pins are plain level signals sampled on the rising clock edge. There is no data path, so there is no valid/ready handshake or back-pressure.

Top module: `dma_chan_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, grant is all zero, grant_busy is 0 and grant_port is 0.
- R2: grant has at most one bit set and is a register output. A decision taken from the inputs sampled at a rising edge appears on grant just after that edge.
- R3: Channel 6 always serves port 0 and channel 7 always serves port 1. Injection channel i (0 to 5) serves port inj_port_sel[i], where 0 means port 0 and 1 means port 1. grant_port shows the port of the granted channel.
- R4: Within one port, a requesting extraction channel wins over every injection channel.
- R5: Among the injection channels of one port, the one with the highest index wins.
- R6: A channel whose en bit is 0 is never granted, even when its req bit is 1.
- R7: Once a channel is granted, grant does not change while that channel's last bit is 0. This holds even if its request or enable falls.
- R8: A decision is taken when grant is zero, or when the granted channel's last bit is 1. If both ports have an eligible candidate, the port recorded as preferred is served. After every grant, the preference moves to the port that was not served. The preference is port 0 after reset.
- R9: If only one port has eligible candidates at a decision, that port is served, even if it was also served by the previous grant.
- R10: At a decision with no eligible channel, grant becomes zero in the next cycle. While grant is zero, a decision is taken in every cycle.
- R11: When the granted channel's last bit is 1 and another eligible channel is waiting, the new grant appears just after that same edge, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 8 | Request per channel; bits 0-5 injection, 6-7 extraction |
| en | input | 8 | Enable per channel |
| last | input | 8 | Last beat of the current frame, per channel |
| inj_port_sel | input | 6 | Port binding of each injection channel (0 = port 0, 1 = port 1) |
| grant | output | 8 | Registered one-hot grant |
| grant_port | output | 1 | Port served by the granted channel |
| grant_busy | output | 1 | High while any channel holds the grant |

## Verification
The bench goes after the cases where the port mapping and the two priority levels interact. One case is an injection channel with a higher index than another, moved to the other port. A design that ignored inj_port_sel would let it win the wrong port. Another case is an extraction channel requesting alongside all six injection channels. A design that ranked by index alone across both ports would still grant channel 7 when port 0 is preferred. Frames whose request drops before the last beat expose a design that releases too early. Back-to-back frames with a waiting channel expose a design that inserts an idle cycle. Runs where only one port requests expose a round-robin that wrongly stalls the lone port. The sweeps cover every mapping word and a spread of request, enable and last-beat patterns.

// File: rtl/dma_chan_arb_pkg.sv
package dma_chan_arb_pkg;
  localparam int unsigned N_PORT = 2;
  localparam int unsigned PORTW  = 1;

  typedef logic [PORTW-1:0] port_t;

  function automatic port_t other_port(input port_t p);
    return ~p;
  endfunction
endpackage

// File: rtl/dca_port_pick.sv
module dca_port_pick
  import dma_chan_arb_pkg::*;
#(
  parameter int unsigned N_INJ = 6,
  parameter int unsigned N_CH  = N_INJ + N_PORT,
  parameter int unsigned IDXW  = $clog2(N_CH),
  parameter int unsigned PORT  = 0
) (
  input  logic [N_CH-1:0]       elig,
  input  logic [N_CH-1:0]       ch_port,
  output logic                  hit,
  output logic [IDXW-1:0]       idx
);
  localparam port_t MY_PORT = port_t'(PORT);

  logic            inj_hit, ext_hit;
  logic [IDXW-1:0] inj_idx, ext_idx;

  // lower level: injection, ascending scan so the highest index is kept
  always_comb begin
    inj_hit = 1'b0;
    inj_idx = '0;
    for (int i = 0; i < int'(N_INJ); i++) begin
      if (elig[i] && (ch_port[i] == MY_PORT)) begin
        inj_hit = 1'b1;
        inj_idx = IDXW'(i);
      end
    end
  end

  // upper level: extraction channels of this port
  always_comb begin
    ext_hit = 1'b0;
    ext_idx = '0;
    for (int j = int'(N_INJ); j < int'(N_CH); j++) begin
      if (elig[j] && (ch_port[j] == MY_PORT)) begin
        ext_hit = 1'b1;
        ext_idx = IDXW'(j);
      end
    end
  end

  assign hit = inj_hit | ext_hit;
  assign idx = ext_hit ? ext_idx : inj_idx;
endmodule

// File: rtl/dca_port_turn.sv
module dca_port_turn
  import dma_chan_arb_pkg::*;
(
  input  logic  hit0,
  input  logic  hit1,
  input  port_t pref,
  output logic  any,
  output port_t pick
);
  always_comb begin
    any = hit0 | hit1;
    if (hit0 && hit1) pick = pref;
    else if (hit1)    pick = port_t'(1);
    else              pick = port_t'(0);
  end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_chan_arb_pkg::*;
#(
  parameter int unsigned N_INJ = 6,
  parameter int unsigned N_CH  = N_INJ + N_PORT,
  parameter int unsigned IDXW  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  req,
  input  logic [N_CH-1:0]  en,
  input  logic [N_CH-1:0]  last,
  input  logic [N_INJ-1:0] inj_port_sel,
  output logic [N_CH-1:0]  grant,
  output logic             grant_port,
  output logic             grant_busy
);
  logic [N_CH-1:0] ch_port;
  logic [N_CH-1:0] elig;
  logic [N_PORT-1:0] hit;
  logic [IDXW-1:0] idx [N_PORT];
  logic            any;
  port_t           pick, pref_q, port_q;
  logic            decide;
  logic [N_CH-1:0] grant_q;

  // port binding of every channel
  for (genvar c = 0; c < int'(N_CH); c++) begin : g_map
    if (c < int'(N_INJ)) begin : g_inj
      assign ch_port[c] = inj_port_sel[c];
    end else begin : g_ext
      assign ch_port[c] = (c - int'(N_INJ)) == 1;
    end
  end

  assign elig = req & en;

  for (genvar p = 0; p < int'(N_PORT); p++) begin : g_port
    dca_port_pick #(
      .N_INJ (N_INJ),
      .N_CH  (N_CH),
      .IDXW  (IDXW),
      .PORT  (p)
    ) u_pick (
      .elig    (elig),
      .ch_port (ch_port),
      .hit     (hit[p]),
      .idx     (idx[p])
    );
  end

  dca_port_turn u_turn (
    .hit0 (hit[0]),
    .hit1 (hit[1]),
    .pref (pref_q),
    .any  (any),
    .pick (pick)
  );

  assign decide = (grant_q == '0) || ((grant_q & last) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      port_q  <= '0;
      pref_q  <= '0;
    end else if (decide) begin
      if (any) begin
        grant_q <= N_CH'(1) << idx[pick];
        port_q  <= pick;
        pref_q  <= other_port(pick);
      end else begin
        grant_q <= '0;
      end
    end
  end

  assign grant      = grant_q;
  assign grant_port = port_q;
  assign grant_busy = |grant_q;
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
  parameter int unsigned N_INJ = 6,
  parameter int unsigned N_CH  = N_INJ + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CH-1:0]  req,
  input logic [N_CH-1:0]  en,
  input logic [N_CH-1:0]  last,
  input logic [N_CH-1:0]  grant,
  input logic             grant_port,
  input logic             grant_busy
);
  logic at_boundary;
  assign at_boundary = (grant == '0) || ((grant & last) != '0);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) && ((grant & last) == '0) |=> $stable(grant));

  // R3
  ext0_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[N_INJ] |-> (grant_port == 1'b0));

  // R3
  ext1_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[N_INJ+1] |-> (grant_port == 1'b1));

  // R6
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_boundary |=> (grant == '0) || ((grant & $past(req & en)) != '0));

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_boundary && ((req & en) == '0) |=> (grant == '0));

  // R11
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_boundary && ((req & en) != '0) |=> grant_busy);
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.N_INJ(N_INJ), .N_CH(N_CH)) u_chk (.*);

// File: tb/dma_chan_arb_bench.sv
module dma_chan_arb_bench;
  localparam int NI = 6;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] req = '0, en = '0, last = '0;
  logic [NI-1:0] sel = '0;
  logic [NC-1:0] grant;
  logic          grant_port, grant_busy;

  int total = 0;
  int bad   = 0;
  logic [NC-1:0] m_grant = '0;
  logic          m_port  = 1'b0;
  logic          m_pref  = 1'b0;
  logic [31:0]   lfsr    = 32'hACE1_2468;

  always #4 clk = ~clk;

  dma_chan_arb u_dma_chan_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .en(en), .last(last),
    .inj_port_sel(sel), .grant(grant), .grant_port(grant_port),
    .grant_busy(grant_busy)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic port_of(input int i, input logic [NI-1:0] s);
    if (i == 6) return 1'b0;
    if (i == 7) return 1'b1;
    return s[i];
  endfunction

  task automatic check(input string tag, input logic [NC-1:0] exp_g, input logic exp_p);
    total++;
    if (grant !== exp_g || grant_busy !== (exp_g != '0) ||
        (exp_g != '0 && grant_port !== exp_p)) begin
      bad++;
      $display("FAIL %s: grant=%b port=%b busy=%b expected grant=%b port=%b",
               tag, grant, grant_port, grant_busy, exp_g, exp_p);
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input string tag, input logic [NC-1:0] r, input logic [NC-1:0] e,
                      input logic [NC-1:0] l, input logic [NI-1:0] s);
    int best0, best1;
    logic [NC-1:0] ng;
    logic np, nf;
    req = r; en = e; last = l; sel = s;
    ng = m_grant; np = m_port; nf = m_pref;
    if (m_grant == '0 || (m_grant & l) != '0) begin
      best0 = -1; best1 = -1;
      for (int i = 0; i < NC; i++)
        if (r[i] && e[i]) begin
          if (port_of(i, s)) best1 = i; else best0 = i;
        end
      if (best0 < 0 && best1 < 0) ng = '0;
      else begin
        if (best0 >= 0 && best1 >= 0) np = m_pref;
        else np = (best1 >= 0);
        ng = NC'(1) << (np ? best1 : best0);
        nf = ~np;
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_grant = ng; m_port = np; m_pref = nf;
    check(tag, m_grant, m_port);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0, 1'b0);
    total++;
    if (grant_port !== 1'b0) begin
      bad++;
      $display("FAIL R1: grant_port=%b expected 0", grant_port);
    end

    // R4: extraction beats all injection on port 0 (all injection on port 0)
    step("R4", 8'h7F, 8'hFF, 8'h00, 6'b000000);
    check("R4 ext ch6", 8'h40, 1'b0);
    step("R4 end", 8'h00, 8'hFF, 8'h40, 6'b000000);
    // R5: highest injection index on its port
    step("R5", 8'h0B, 8'hFF, 8'h00, 6'b000000);
    check("R5 ch3", 8'h08, 1'b0);
    // R7: request falls mid-frame, grant held
    step("R7", 8'h00, 8'hFF, 8'h00, 6'b000000);
    check("R7 held", 8'h08, 1'b0);
    // R11: last with waiting channel, switch with no gap (pref now 1, only port 0 waits -> R9)
    step("R11", 8'h01, 8'hFF, 8'h08, 6'b000000);
    check("R11 R9 ch0", 8'h01, 1'b0);
    // R3: ch5 moved to port 1, ch2 on port 0; pref is 1 -> ch5 on port 1
    step("R3", 8'h24, 8'hFF, 8'h01, 6'b100000);
    check("R3 ch5 port1", 8'h20, 1'b1);
    // R8: both ports waiting; pref now 0 -> ch2
    step("R8", 8'h24, 8'hFF, 8'h20, 6'b100000);
    check("R8 alternate", 8'h04, 1'b0);
    // R6: channel 7 requests but disabled; ch5 served
    step("R6", 8'hA0, 8'h7F, 8'h04, 6'b100000);
    check("R6 disabled ignored", 8'h20, 1'b1);
    // R10: nothing eligible at the boundary
    step("R10", 8'h80, 8'h7F, 8'h20, 6'b100000);
    check("R10 cleared", 8'h00, 1'b0);

    // sweep every mapping word over a spread of request patterns
    for (int s = 0; s < 64; s++)
      for (int r = 0; r < 256; r += 7) begin
        lfsr = nxt(lfsr);
        step("R3 R4 R5 R8 R9 sweep", NC'(r), 8'hFF, lfsr[7:0] & lfsr[15:8], NI'(s));
      end

    // random enables, requests and frame ends
    for (int k = 0; k < 4000; k++) begin
      lfsr = nxt(lfsr);
      step("R6 R7 R10 R11 random", lfsr[7:0], lfsr[15:8] | lfsr[23:16], lfsr[31:24] & lfsr[11:4],
           lfsr[21:16]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule